// File: doc/BRIEF.md
# Zero-Suppressing Sample Tagger

This block sits behind one front-end digitiser that serves a fixed set of pad channels. In every beam crossing the digitiser delivers one sample per channel, in ascending channel order. The block subtracts a per-channel baseline from each sample and compares the result with a per-channel cut. Only samples above the cut are kept. Each kept sample leaves as a record: the raw sample word plus a 32-bit tag that holds the channel number and the crossing number.

A small output queue absorbs bursts of kept samples, so the downstream link can drain at its own pace through a valid/ready handshake. If the queue is full, new kept samples are discarded. A sticky flag and a saturating counter record each loss. A simple write port fills the baseline and cut tables. A bypass input turns off suppression so that every sample is forwarded, which serves baseline and noise calibration runs.

A train-start pulse marks the first sample of a bunch train. It restarts the channel and crossing counts.

Top module: `zs_tagger`

## Requirements
- R1: During and straight after a synchronous reset, `out_valid`, `overflow` and `drop_count` are all zero, and the next train starts at crossing 0.
- R2: Samples are numbered 0 to NUM_CH-1 in arrival order from a train start. In the output tag, the channel number is in bits [31:24] and bits [7:0] are zero.
- R3: Tag bits [23:8] hold the crossing number. A sample that arrives together with `train_start` belongs to crossing 0. The crossing number goes up by one after channel NUM_CH-1 of each sweep.
- R4: With bypass low, a sample is kept only when the signed difference (sample[13:0] - baseline[13:0]) is strictly greater than the cut, read as a signed 16-bit value. A difference equal to the cut is discarded. Negative differences and negative cuts compare as signed. Sample bits [15:14] take no part in the comparison.
- R5: A write with `cfg_sel`=0 stores `cfg_wdata` as the baseline of channel `cfg_addr`. A write with `cfg_sel`=1 stores it as that channel's cut. The new values apply to later samples of that channel only.
- R6: With `bypass` high, every sample is forwarded, whatever its value.
- R7: Kept samples leave in arrival order. `out_sample` carries the full 16-bit input word, unchanged.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sample` and `out_label` stay unchanged.
- R9: A kept sample that meets a full queue is discarded. `overflow` then rises and stays high until reset. `drop_count` goes up by one per lost sample and stops at its all-ones value. Samples already in the queue are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_start | input | 1 | Marks the first sample of a train; clears channel and crossing counts |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_data | input | 16 | Sample word, converter value in bits [13:0] |
| bypass | input | 1 | Forward every sample unsuppressed |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | Table select: 0 baseline, 1 cut |
| cfg_addr | input | CH_W | Channel written |
| cfg_wdata | input | 16 | Value written |
| out_valid | output | 1 | A record is available |
| out_ready | input | 1 | Downstream accepts the record |
| out_sample | output | 16 | Raw sample word of the record |
| out_label | output | 32 | Tag: channel [31:24], crossing [23:8], zero [7:0] |
| overflow | output | 1 | Sticky: a kept sample was lost |
| drop_count | output | DROP_W | Saturating count of lost samples |

## Verification
The bench drives sweeps of patterns chosen per channel to separate the cases of the cut comparison:
- one count above the cut is kept, a value exactly at the cut is discarded, and values far below the baseline are discarded;
- samples with the top two bits set show that those bits are forwarded but not compared;
- a negative cut accepts a difference one count above it and rejects one exactly on it, which tells signed from unsigned comparison.

Sweeps with kept samples only at the first and last channels, repeated without and then with a train start, show where the crossing count advances and where it restarts. A bypass sweep of values that would all be suppressed shows that bypass overrides the cut. A stalled link first holds records still and then, with bypass on, overflows the queue. After that, only the first queued records should drain, with the loss count pinned at its maximum.

// File: rtl/zs_pkg.sv
package zs_pkg;
  localparam int SAMPLE_W = 16;
  localparam int LABEL_W  = 32;
  localparam int XING_W   = 16;
  localparam int CHF_W    = 8;
  localparam int REC_W    = SAMPLE_W + LABEL_W;

  typedef enum logic {TBL_PED = 1'b0, TBL_THR = 1'b1} tbl_sel_e;

  typedef struct packed {
    logic [SAMPLE_W-1:0] sample;
    logic [LABEL_W-1:0]  label;
  } zs_rec_t;
endpackage

// File: rtl/zs_sweep_ctr.sv
module zs_sweep_ctr #(
  parameter int NUM_CH = 128,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int XW     = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            train_start,
  input  logic            smp_valid,
  output logic [CH_W-1:0] cur_ch,
  output logic [XW-1:0]   cur_xing
);
  logic [CH_W-1:0] ch_q;
  logic [XW-1:0]   x_q;
  logic            last;

  always_comb begin
    cur_ch   = train_start ? '0 : ch_q;
    cur_xing = train_start ? '0 : x_q;
    last     = (cur_ch == CH_W'(NUM_CH - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_q <= '0;
      x_q  <= '0;
    end else if (smp_valid) begin
      ch_q <= last ? '0 : cur_ch + 1'b1;
      x_q  <= last ? cur_xing + 1'b1 : cur_xing;
    end else if (train_start) begin
      ch_q <= '0;
      x_q  <= '0;
    end
  end
endmodule

// File: rtl/zs_cfg_tables.sv
module zs_cfg_tables #(
  parameter int NUM_CH = 128,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int W      = 16
) (
  input  logic            clk,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [CH_W-1:0] cfg_addr,
  input  logic [W-1:0]    cfg_wdata,
  input  logic [CH_W-1:0] rd_addr,
  output logic [W-1:0]    ped_q,
  output logic [W-1:0]    thr_q
);
  logic [W-1:0] rd_q [2];

  for (genvar t = 0; t < 2; t++) begin : g_tbl
    logic [W-1:0] mem [NUM_CH];
    always_ff @(posedge clk) begin
      if (cfg_we && (cfg_sel == t[0])) mem[cfg_addr] <= cfg_wdata;
      rd_q[t] <= mem[rd_addr];
    end
  end

  assign ped_q = rd_q[zs_pkg::TBL_PED];
  assign thr_q = rd_q[zs_pkg::TBL_THR];
endmodule

// File: rtl/zs_fifo.sv
module zs_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 48,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/zs_tagger.sv
module zs_tagger #(
  parameter int NUM_CH     = 128,
  parameter int CH_W       = $clog2(NUM_CH),
  parameter int ADC_W      = 14,
  parameter int FIFO_DEPTH = 16,
  parameter int DROP_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              train_start,
  input  logic              smp_valid,
  input  logic [15:0]       smp_data,
  input  logic              bypass,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CH_W-1:0]   cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [15:0]       out_sample,
  output logic [31:0]       out_label,
  output logic              overflow,
  output logic [DROP_W-1:0] drop_count
);
  import zs_pkg::*;
  localparam int DW = SAMPLE_W + 1;

  logic [CH_W-1:0]     cur_ch, s1_ch;
  logic [XING_W-1:0]   cur_xing, s1_xing;
  logic                s1_valid;
  logic [SAMPLE_W-1:0] s1_data, ped_q, thr_q;
  logic [DW-1:0]       diff, thr_ext;
  logic                keep, full, empty, push, drop;
  zs_rec_t             rec_in, rec_out;

  zs_sweep_ctr #(.NUM_CH(NUM_CH), .CH_W(CH_W), .XW(XING_W)) u_ctr (
    .clk(clk), .rst(rst), .train_start(train_start), .smp_valid(smp_valid),
    .cur_ch(cur_ch), .cur_xing(cur_xing)
  );

  zs_cfg_tables #(.NUM_CH(NUM_CH), .CH_W(CH_W), .W(SAMPLE_W)) u_tbl (
    .clk(clk), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_addr(cur_ch), .ped_q(ped_q), .thr_q(thr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= smp_valid;
    end
    s1_data <= smp_data;
    s1_ch   <= cur_ch;
    s1_xing <= cur_xing;
  end

  always_comb begin
    diff    = {{(DW-ADC_W){1'b0}}, s1_data[ADC_W-1:0]}
            - {{(DW-ADC_W){1'b0}}, ped_q[ADC_W-1:0]};
    thr_ext = {thr_q[SAMPLE_W-1], thr_q};
    keep    = s1_valid && (bypass || ($signed(diff) > $signed(thr_ext)));
    push    = keep && !full;
    drop    = keep && full;
    rec_in.sample = s1_data;
    rec_in.label  = {CHF_W'(s1_ch), s1_xing, 8'h00};
  end

  zs_fifo #(.DEPTH(FIFO_DEPTH), .W(REC_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(rec_in),
    .pop(out_ready), .dout(rec_out), .empty(empty), .full(full)
  );

  assign out_valid  = !empty;
  assign out_sample = rec_out.sample;
  assign out_label  = rec_out.label;

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow   <= 1'b0;
      drop_count <= '0;
    end else if (drop) begin
      overflow <= 1'b1;
      if (drop_count != '1) drop_count <= drop_count + 1'b1;
    end
  end
endmodule

// File: rtl/zs_tagger_chk.sv
module zs_tagger_chk #(
  parameter int NUM_CH = 128,
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_ready,
  input logic [15:0]       out_sample,
  input logic [31:0]       out_label,
  input logic              overflow,
  input logic [DROP_W-1:0] drop_count
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !overflow && drop_count == '0));

  assert_label_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_label[7:0] == 8'h00));

  assert_chan_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({24'b0, out_label[31:24]} < 32'(NUM_CH)));

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_sample) && $stable(out_label)));

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_drop_step_R9: assert property (@(posedge clk) disable iff (rst)
    (drop_count != $past(drop_count)) |->
      (overflow && drop_count == $past(drop_count) + 1'b1));
endmodule

bind zs_tagger zs_tagger_chk #(.NUM_CH(NUM_CH), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_sample(out_sample), .out_label(out_label), .overflow(overflow),
  .drop_count(drop_count)
);

// File: tb/test_zs_tagger.sv
module test_zs_tagger;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 128;
  localparam int CH_W       = $clog2(NUM_CH);
  localparam int DEPTH      = 16;
  localparam int DROP_W     = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic train_start = 0, smp_valid = 0, bypass = 0, cfg_we = 0, cfg_sel = 0;
  logic [15:0] smp_data = '0, cfg_wdata = '0;
  logic [CH_W-1:0] cfg_addr = '0;
  logic out_valid, out_ready = 1'b1, overflow;
  logic [15:0] out_sample;
  logic [31:0] out_label;
  logic [DROP_W-1:0] drop_count;

  int checks = 0, errors = 0;
  bit done = 0;
  int exp_x = 0;
  logic [15:0] b_ped [NUM_CH];
  logic [15:0] b_thr [NUM_CH];
  logic [15:0] sweep_val [NUM_CH];
  bit          sweep_keep [NUM_CH];
  logic [47:0] exp_q [$];
  logic [47:0] got_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  zs_tagger #(.NUM_CH(NUM_CH), .FIFO_DEPTH(DEPTH), .DROP_W(DROP_W)) i_zs_tagger (
    .clk(clk), .rst(rst), .train_start(train_start), .smp_valid(smp_valid),
    .smp_data(smp_data), .bypass(bypass), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_sample(out_sample), .out_label(out_label),
    .overflow(overflow), .drop_count(drop_count)
  );

  always @(negedge clk)
    if (!rst && out_valid && out_ready) got_q.push_back({out_sample, out_label});

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input bit sel, input int ch, input logic [15:0] v);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = sel; cfg_addr = CH_W'(ch); cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 0;
    if (sel) b_thr[ch] = v; else b_ped[ch] = v;
  endtask

  task automatic run_sweep(input bit do_train);
    if (do_train) exp_x = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      @(posedge clk); #1;
      smp_valid = 1; smp_data = sweep_val[c]; train_start = do_train && (c == 0);
      if (sweep_keep[c])
        exp_q.push_back({sweep_val[c], 8'(c), 16'(exp_x), 8'h00});
    end
    @(posedge clk); #1;
    smp_valid = 0; train_start = 0;
    exp_x++;
  endtask

  task automatic drain(input string tag);
    int w = 0;
    while (got_q.size() < exp_q.size() && w < 4000) begin
      @(posedge clk); w++;
    end
    repeat (4) @(posedge clk);
    chk(got_q.size() == exp_q.size(), {tag, " record count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], {tag, " record"}, got_q[i], exp_q[i]);
    exp_q.delete(); got_q.delete();
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(overflow == 0, "R1 overflow after reset", overflow, 0);
    chk(drop_count == 0, "R1 drop_count after reset", drop_count, 0);
  endtask

  task automatic t_config;
    for (int c = 0; c < NUM_CH; c++) begin
      cfg_write(0, c, 16'(100 + c));
      cfg_write(1, c, 16'd20);
    end
  endtask

  // R2 R4 R5 R7: kept above cut, discarded at cut, upper bits raw
  task automatic t_threshold;
    for (int c = 0; c < NUM_CH; c++) begin
      case (c % 4)
        0: begin sweep_val[c] = b_ped[c] + 16'd21; sweep_keep[c] = 1; end
        1: begin sweep_val[c] = b_ped[c] + 16'd20; sweep_keep[c] = 0; end
        2: begin sweep_val[c] = 16'hC000 | (b_ped[c] + 16'd500); sweep_keep[c] = 1; end
        default: begin sweep_val[c] = b_ped[c] - 16'd50; sweep_keep[c] = 0; end
      endcase
    end
    run_sweep(1);
    drain("R2 R4 R5 R7 threshold sweep");
  endtask

  // R3: crossing advances after last channel, restarts on train start
  task automatic t_crossing;
    for (int c = 0; c < NUM_CH; c++) begin
      sweep_keep[c] = (c == 0) || (c == NUM_CH - 1);
      sweep_val[c]  = b_ped[c] + (sweep_keep[c] ? 16'd30 : 16'd0);
    end
    run_sweep(1);
    run_sweep(0);
    run_sweep(0);
    run_sweep(1);
    drain("R3 crossing label");
  endtask

  // R4 R5: negative cut compares signed
  task automatic t_negative;
    cfg_write(1, 3, 16'hFFFB);
    cfg_write(1, 4, 16'hFFFB);
    for (int c = 0; c < NUM_CH; c++) begin
      sweep_val[c] = b_ped[c]; sweep_keep[c] = 0;
    end
    sweep_val[3] = b_ped[3] - 16'd4; sweep_keep[3] = 1;
    sweep_val[4] = b_ped[4] - 16'd5;
    run_sweep(1);
    drain("R4 R5 negative cut");
    cfg_write(1, 3, 16'd20);
    cfg_write(1, 4, 16'd20);
  endtask

  // R6: bypass forwards samples that would be cut
  task automatic t_bypass;
    bypass = 1;
    for (int c = 0; c < NUM_CH; c++) begin
      sweep_val[c] = b_ped[c] - 16'd50; sweep_keep[c] = 1;
    end
    run_sweep(1);
    drain("R6 bypass");
    bypass = 0;
  endtask

  // R8: stalled output holds still
  task automatic t_backpressure;
    logic [15:0] s0;
    logic [31:0] l0;
    out_ready = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      sweep_keep[c] = (c == 5) || (c == 9);
      sweep_val[c]  = b_ped[c] + (sweep_keep[c] ? 16'd21 : 16'd0);
    end
    run_sweep(1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    s0 = out_sample; l0 = out_label;
    chk(out_valid == 1, "R8 valid while stalled", out_valid, 1);
    chk(s0 == b_ped[5] + 16'd21, "R8 head sample", s0, b_ped[5] + 16'd21);
    repeat (5) @(negedge clk);
    chk(out_valid == 1 && out_sample == s0 && out_label == l0, "R8 held record",
        {out_sample, out_label}, {s0, l0});
    @(posedge clk); #1;
    out_ready = 1;
    drain("R8 release");
  endtask

  // R9: full queue drops, flag sticky, counter saturates
  task automatic t_overflow;
    int x0;
    @(negedge clk);
    chk(overflow == 0, "R9 no overflow yet", overflow, 0);
    out_ready = 0; bypass = 1;
    for (int c = 0; c < NUM_CH; c++) begin
      sweep_val[c] = 16'(1000 + c); sweep_keep[c] = 0;
    end
    run_sweep(1);
    x0 = 0;
    run_sweep(0);
    run_sweep(0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(overflow == 1, "R9 overflow set", overflow, 1);
    chk(drop_count == '1, "R9 drop_count saturated", drop_count, 8'hFF);
    for (int c = 0; c < DEPTH; c++)
      exp_q.push_back({16'(1000 + c), 8'(c), 16'(x0), 8'h00});
    @(posedge clk); #1;
    out_ready = 1; bypass = 0;
    drain("R9 queued records kept");
    @(negedge clk);
    chk(overflow == 1, "R9 overflow sticky", overflow, 1);
    chk(drop_count == '1, "R9 drop_count held", drop_count, 8'hFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_config();
    t_threshold();
    t_crossing();
    t_negative();
    t_bypass();
    t_backpressure();
    t_overflow();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule